// File: doc/BRIEF.md
# Two-Port Interprocessor Mailbox

This block lets two processors exchange 32-bit messages. Each processor has its own register port with a select, a write flag, a byte address and write data. The block holds eight one-way channels. Every channel is a small FIFO whose sender is chosen by two shared direction bits. The sending side writes a word to the channel's data register to push it. The receiving side reads the same register to pop the oldest word.

Each side has an interrupt enable register and an interrupt status register, with two bits per channel, and one level interrupt output. A receive bit sets whenever a word lands in a channel that side receives. The receive bit cannot be cleared while that FIFO still holds words. Each side can also read the other side's enable and status registers. A sender therefore treats its message as consumed once the peer's receive bit for that channel has dropped.

Top module: `mbox_dual`

## Requirements
- R1: After reset, every direction bit, enable bit, status bit and FIFO count is zero, both interrupt outputs are low, and both read data outputs are zero.
- R2: Direction words sit at byte addresses 0x000 (channels 0 to 3) and 0x004 (channels 4 to 7). For channel n, bit 8*(n%4) selects side B as sender, and bit 8*(n%4)+4 selects side A as sender; the A bit wins when both are set. Either port may write these words, and both ports read the same value back.
- R3: The receiving side reads channel n's FIFO at 0x180+4n, oldest word first. The message count at 0x140+4n (bits 2:0) reports the number of stored words, from 0 to 4. Read data appears on the port's rdata one cycle after the read access.
- R4: The FIFO holds 4 words. Bit 0 of 0x100+4n reads 1 when channel n is full. A write to a full FIFO is dropped.
- R5: A read of an empty FIFO returns zero and leaves the count at zero.
- R6: A data write from a side that is not channel n's sender changes nothing; this includes writes to a channel with neither direction bit set.
- R7: In a side's status register at 0x070, bit 2n sets when a word is pushed into channel n and that side is the receiver. Writing 1 to the bit clears it only when the FIFO is empty; otherwise the bit stays set.
- R8: Status bit 2n+1 is set in every cycle in which that side is channel n's sender and the FIFO is not full. Writing 1 to the bit clears it only while the FIFO stays full.
- R9: The interrupt enable register sits at 0x060. A side's interrupt output is high exactly when its enable and status registers share a set bit.
- R10: Address 0x040 reads the peer's enable register and 0x050 reads the peer's status register. Writes to these two addresses have no effect.
- R11: A push and a pop on the same channel in the same cycle both take effect: the count is unchanged and word order is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_sel | input | 1 | Side A access strobe |
| a_wr | input | 1 | Side A write (1) or read (0) |
| a_addr | input | 10 | Side A byte address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, one cycle after the access |
| irq_a | output | 1 | Side A interrupt, level |
| b_sel | input | 1 | Side B access strobe |
| b_wr | input | 1 | Side B write (1) or read (0) |
| b_addr | input | 10 | Side B byte address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, one cycle after the access |
| irq_b | output | 1 | Side B interrupt, level |

## Verification
A write updates FIFO contents, counts, enables and status bits at the clock edge where it is accepted. A read returns a_rdata or b_rdata one edge after the access, and the interrupt outputs follow the updated registers with no further delay. The one exception is the transmit status bit: it is set from the previous cycle's fullness, so it reappears one edge after a pop frees a slot. Every bench access is driven at a falling edge and its result is sampled at the next falling edge. After a pop, the bench waits one idle cycle before it reads the transmit bit, so every sample lands after the edge that produced it.

// File: rtl/mbox_dual.sv
module mbox_dual #(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_sel,
  input  logic          a_wr,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          irq_a,
  input  logic          b_sel,
  input  logic          b_wr,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          irq_b
);
  localparam int NCH = 8;
  localparam int IW  = 2 * NCH;
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [NCH-1:0] dir_rx, dir_tx, snd_a, snd_b, full, empty, push, pop;
  logic [NCH-1:0][CW-1:0] cnt;
  logic [IW-1:0] en_a, en_b, st_a, st_b, set_a, set_b, clr_a, clr_b;
  logic [DW-1:0] head [NCH];

  assign snd_a = dir_tx;
  assign snd_b = dir_rx & ~dir_tx;

  wire a_w = a_sel & a_wr;
  wire a_r = a_sel & ~a_wr;
  wire b_w = b_sel & b_wr;
  wire b_r = b_sel & ~b_wr;

  wire a_dat = (a_addr[AW-1:8] == 'd1) && (a_addr[7:6] == 2'd2) && !a_addr[5] && (a_addr[1:0] == 2'd0);
  wire b_dat = (b_addr[AW-1:8] == 'd1) && (b_addr[7:6] == 2'd2) && !b_addr[5] && (b_addr[1:0] == 2'd0);
  wire a_stw = a_w && (a_addr == AW'('h70));
  wire b_stw = b_w && (b_addr == AW'('h70));

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] c;
    wire a_hit = a_dat && (a_addr[4:2] == 3'(n));
    wire b_hit = b_dat && (b_addr[4:2] == 3'(n));
    wire [DW-1:0] wd = snd_a[n] ? a_wdata : b_wdata;

    assign cnt[n]   = c;
    assign full[n]  = (c == CW'(DEPTH));
    assign empty[n] = (c == '0);
    assign push[n]  = !full[n] && ((a_w && a_hit && snd_a[n]) || (b_w && b_hit && snd_b[n]));
    assign pop[n]   = !empty[n] && ((a_r && a_hit && snd_b[n]) || (b_r && b_hit && snd_a[n]));
    assign head[n]  = mem[rp];

    assign set_a[2*n]   = push[n] & snd_b[n];
    assign set_a[2*n+1] = snd_a[n] & ~full[n];
    assign set_b[2*n]   = push[n] & snd_a[n];
    assign set_b[2*n+1] = snd_b[n] & ~full[n];
    assign clr_a[2*n]   = a_stw & a_wdata[2*n] & empty[n];
    assign clr_a[2*n+1] = a_stw & a_wdata[2*n+1];
    assign clr_b[2*n]   = b_stw & b_wdata[2*n] & empty[n];
    assign clr_b[2*n+1] = b_stw & b_wdata[2*n+1];

    always_ff @(posedge clk)
      if (push[n]) mem[wp] <= wd;

    always_ff @(posedge clk) begin
      if (rst) begin
        wp <= '0;
        rp <= '0;
        c  <= '0;
      end else begin
        if (push[n]) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
        if (pop[n])  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
        c <= c + CW'(push[n]) - CW'(pop[n]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_rx <= '0;
      dir_tx <= '0;
      en_a   <= '0;
      en_b   <= '0;
      st_a   <= '0;
      st_b   <= '0;
    end else begin
      for (int w = 0; w < NCH / 4; w++) begin
        if (a_w && a_addr == AW'(4 * w)) begin
          for (int k = 0; k < 4; k++) begin
            dir_rx[4*w+k] <= a_wdata[8*k];
            dir_tx[4*w+k] <= a_wdata[8*k+4];
          end
        end else if (b_w && b_addr == AW'(4 * w)) begin
          for (int k = 0; k < 4; k++) begin
            dir_rx[4*w+k] <= b_wdata[8*k];
            dir_tx[4*w+k] <= b_wdata[8*k+4];
          end
        end
      end
      if (a_w && a_addr == AW'('h60)) en_a <= a_wdata[IW-1:0];
      if (b_w && b_addr == AW'('h60)) en_b <= b_wdata[IW-1:0];
      st_a <= (st_a & ~clr_a) | set_a;
      st_b <= (st_b & ~clr_b) | set_b;
    end
  end

  function automatic logic [DW-1:0] rd_word(input logic [AW-1:0] ad, input logic [IW-1:0] eo,
                                            input logic [IW-1:0] so, input logic [IW-1:0] ep,
                                            input logic [IW-1:0] sp, input logic [NCH-1:0] rcv);
    logic [DW-1:0] v;
    logic [2:0] ch;
    v  = '0;
    ch = ad[4:2];
    if (ad[AW-1:8] == '0) begin
      case (ad[7:0])
        8'h00, 8'h04:
          for (int k = 0; k < 4; k++) begin
            v[8*k]   = dir_rx[4*ad[2]+k];
            v[8*k+4] = dir_tx[4*ad[2]+k];
          end
        8'h40: v[IW-1:0] = ep;
        8'h50: v[IW-1:0] = sp;
        8'h60: v[IW-1:0] = eo;
        8'h70: v[IW-1:0] = so;
        default: v = '0;
      endcase
    end else if (ad[AW-1:8] == 'd1 && !ad[5] && ad[1:0] == 2'd0) begin
      case (ad[7:6])
        2'd0: v[0] = full[ch];
        2'd1: v[CW-1:0] = cnt[ch];
        2'd2: if (rcv[ch] && !empty[ch]) v = head[ch];
        default: v = '0;
      endcase
    end
    return v;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      a_rdata <= '0;
      b_rdata <= '0;
    end else begin
      if (a_r) a_rdata <= rd_word(a_addr, en_a, st_a, en_b, st_b, snd_b);
      if (b_r) b_rdata <= rd_word(b_addr, en_b, st_b, en_a, st_a, snd_a);
    end
  end

  assign irq_a = |(en_a & st_a);
  assign irq_b = |(en_b & st_b);
endmodule

// File: rtl/mbox_dual_chk.sv
module mbox_dual_chk #(
  parameter int NCH   = 8,
  parameter int DEPTH = 4,
  parameter int CW    = 3,
  parameter int IW    = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   irq_a,
  input logic                   irq_b,
  input logic [IW-1:0]          en_a,
  input logic [IW-1:0]          en_b,
  input logic [IW-1:0]          st_a,
  input logic [IW-1:0]          st_b,
  input logic [NCH-1:0][CW-1:0] cnt
);
  p_irq_needs_en_r9: assert property (@(posedge clk) disable iff (rst) irq_a |-> (en_a != '0));
  p_irq_needs_en_b_r9: assert property (@(posedge clk) disable iff (rst) irq_b |-> (en_b != '0));

  for (genvar n = 0; n < NCH; n++) begin : g_c
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst) int'(cnt[n]) <= DEPTH);
    p_count_step_r11: assert property (@(posedge clk) disable iff (rst)
      (int'(cnt[n]) == int'($past(cnt[n]))) || (int'(cnt[n]) == int'($past(cnt[n])) + 1) ||
      (int'(cnt[n]) + 1 == int'($past(cnt[n]))));
    p_rx_hold_a_r7: assert property (@(posedge clk) disable iff (rst)
      (st_a[2*n] && cnt[n] != '0) |=> st_a[2*n]);
    p_rx_hold_b_r7: assert property (@(posedge clk) disable iff (rst)
      (st_b[2*n] && cnt[n] != '0) |=> st_b[2*n]);
  end
endmodule

bind mbox_dual mbox_dual_chk #(.NCH(NCH), .DEPTH(DEPTH), .CW(CW), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .irq_a(irq_a), .irq_b(irq_b), .en_a(en_a), .en_b(en_b),
  .st_a(st_a), .st_b(st_b), .cnt(cnt));

// File: tb/sim_mbox_dual.sv
`timescale 1ns/1ps
module sim_mbox_dual;
  localparam int DEPTH = 4;
  logic clk = 0, rst = 1;
  logic a_sel = 0, a_wr = 0, b_sel = 0, b_wr = 0;
  logic [9:0] a_addr = 0, b_addr = 0;
  logic [31:0] a_wdata = 0, b_wdata = 0, a_rdata, b_rdata;
  logic irq_a, irq_b;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  mbox_dual u0 (.clk(clk), .rst(rst), .a_sel(a_sel), .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .irq_a(irq_a), .b_sel(b_sel), .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .irq_b(irq_b));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input bit side_b, input logic [9:0] ad, input logic [31:0] d);
    @(negedge clk);
    if (side_b) begin b_sel = 1; b_wr = 1; b_addr = ad; b_wdata = d; end
    else begin a_sel = 1; a_wr = 1; a_addr = ad; a_wdata = d; end
    @(negedge clk);
    a_sel = 0; b_sel = 0; a_wr = 0; b_wr = 0;
  endtask

  task automatic rd(input bit side_b, input logic [9:0] ad, output logic [31:0] d);
    @(negedge clk);
    if (side_b) begin b_sel = 1; b_wr = 0; b_addr = ad; end
    else begin a_sel = 1; a_wr = 0; a_addr = ad; end
    @(negedge clk);
    a_sel = 0; b_sel = 0;
    d = side_b ? b_rdata : a_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq_a", {31'b0, irq_a}, 0);
    chk("R1 irq_b", {31'b0, irq_b}, 0);
    chk("R1 rdata", a_rdata | b_rdata, 0);
    rd(0, 10'h070, d); chk("R1 status A", d, 0);
    rd(1, 10'h070, d); chk("R1 status B", d, 0);
    rd(1, 10'h140, d); chk("R1 count ch0", d, 0);
    rd(0, 10'h000, d); chk("R1 dir word0", d, 0);
  endtask

  task automatic t_dir;
    logic [31:0] d;
    wr(0, 10'h000, 32'h0000_0110);
    rd(1, 10'h000, d); chk("R2 word0 via B", d, 32'h0000_0110);
    wr(1, 10'h004, 32'h0000_1000);
    rd(0, 10'h004, d); chk("R2 word1 via A", d, 32'h0000_1000);
    wr(1, 10'h004, 32'h0);
    rd(0, 10'h004, d); chk("R2 word1 cleared", d, 0);
  endtask

  task automatic t_fifo;
    logic [31:0] d;
    for (int i = 0; i < 3; i++) wr(0, 10'h180, 32'hC0DE_0000 + i);
    rd(1, 10'h140, d); chk("R3 count 3", d, 3);
    for (int i = 0; i < 3; i++) begin
      rd(1, 10'h180, d); chk("R3 order", d, 32'hC0DE_0000 + i);
    end
    rd(1, 10'h140, d); chk("R3 count 0", d, 0);
    wr(1, 10'h184, 32'h5151_0001);
    rd(0, 10'h184, d); chk("R3 B-to-A ch1", d, 32'h5151_0001);
  endtask

  task automatic t_full;
    logic [31:0] d;
    for (int i = 0; i < DEPTH + 1; i++) wr(0, 10'h180, 32'hF000_0000 + i);
    rd(1, 10'h100, d); chk("R4 full flag", d, 1);
    rd(1, 10'h140, d); chk("R4 count at depth", d, DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      rd(1, 10'h180, d); chk("R4 kept words", d, 32'hF000_0000 + i);
    end
    rd(1, 10'h100, d); chk("R4 not full", d, 0);
  endtask

  task automatic t_empty;
    logic [31:0] d;
    rd(1, 10'h180, d); chk("R5 empty read", d, 0);
    rd(1, 10'h140, d); chk("R5 count stays 0", d, 0);
  endtask

  task automatic t_wrong;
    logic [31:0] d;
    wr(1, 10'h180, 32'hBAD0_0000);
    wr(0, 10'h184, 32'hBAD0_0001);
    wr(0, 10'h188, 32'hBAD0_0002);
    rd(0, 10'h140, d); chk("R6 ch0 backwards", d, 0);
    rd(0, 10'h144, d); chk("R6 ch1 backwards", d, 0);
    rd(0, 10'h148, d); chk("R6 ch2 unconfigured", d, 0);
  endtask

  task automatic t_rx;
    logic [31:0] d;
    wr(1, 10'h060, 32'h1);
    wr(0, 10'h180, 32'h1234_5678);
    chk("R9 irq_b on receive", {31'b0, irq_b}, 1);
    rd(1, 10'h070, d); chk("R7 rx bit set", d & 32'h1, 1);
    wr(1, 10'h070, 32'h1);
    rd(1, 10'h070, d); chk("R7 rx bit held while data", d & 32'h1, 1);
    rd(0, 10'h050, d); chk("R10 peer status busy", d & 32'h1, 1);
    wr(0, 10'h050, 32'hFFFF);
    rd(1, 10'h180, d); chk("R7 message", d, 32'h1234_5678);
    wr(1, 10'h070, 32'h1);
    rd(1, 10'h070, d); chk("R7 rx bit cleared", d & 32'h1, 0);
    chk("R9 irq_b low", {31'b0, irq_b}, 0);
    rd(0, 10'h050, d); chk("R10 peer ack", d & 32'h1, 0);
    rd(0, 10'h040, d); chk("R10 peer enable", d, 1);
    wr(1, 10'h060, 32'h0);
  endtask

  task automatic t_tx;
    logic [31:0] d;
    wr(0, 10'h060, 32'h2);
    chk("R9 irq_a tx ready", {31'b0, irq_a}, 1);
    for (int i = 0; i < DEPTH; i++) wr(0, 10'h180, 32'h7700_0000 + i);
    wr(0, 10'h070, 32'h2);
    rd(0, 10'h070, d); chk("R8 tx bit cleared when full", d & 32'h2, 0);
    chk("R9 irq_a low", {31'b0, irq_a}, 0);
    rd(1, 10'h180, d);
    @(negedge clk);
    rd(0, 10'h070, d); chk("R8 tx bit back after pop", d & 32'h2, 2);
    chk("R9 irq_a back", {31'b0, irq_a}, 1);
    for (int i = 1; i < DEPTH; i++) rd(1, 10'h180, d);
    wr(0, 10'h060, 32'h0);
  endtask

  task automatic t_simul;
    logic [31:0] d;
    wr(0, 10'h180, 32'hAB00_0000);
    wr(0, 10'h180, 32'hAB00_0001);
    @(negedge clk);
    a_sel = 1; a_wr = 1; a_addr = 10'h180; a_wdata = 32'hAB00_0002;
    b_sel = 1; b_wr = 0; b_addr = 10'h180;
    @(negedge clk);
    a_sel = 0; b_sel = 0; a_wr = 0;
    chk("R11 popped head", b_rdata, 32'hAB00_0000);
    rd(1, 10'h140, d); chk("R11 count unchanged", d, 2);
    rd(1, 10'h180, d); chk("R11 order 1", d, 32'hAB00_0001);
    rd(1, 10'h180, d); chk("R11 order 2", d, 32'hAB00_0002);
  endtask

  initial begin
    #(4 * 100000);
    n_chk++; n_fail++;
    $display("FAIL all requirements: watchdog, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset;
    t_dir;
    t_fifo;
    t_full;
    t_empty;
    t_wrong;
    t_rx;
    t_tx;
    t_simul;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule